// File: doc/BRIEF.md
# Interrupt Status Register Bank

This block is a small memory-mapped bank of single-bit fields whose host writes act in only one direction. Status bits are raised by per-bit hardware pulses and dropped by host writes. Control bits are raised by host writes and dropped by per-bit hardware pulses. Both kinds come in a variant that acts on a written 1 and a variant that acts on a written 0.

Every status bit is an interrupt source with its own enable bit. One registered line reports whether any enabled status bit is set. The host side is a plain command port: valid, write flag, byte address, data and a per-bit write mask. Read data is returned combinationally for the address on the port.

The bank has three word registers on 4-byte boundaries. Each register holds `NUM_SRC` bits in a low group starting at bit 0 and `NUM_SRC` bits in a high group starting at bit `HI_LSB` (16 by default). The per-bit hardware vectors and the `ctrl_value` output use the order {high group, low group}.

Top module: `irq_status_bank`

## Requirements
- R1: After reset, all three registers read 0, `ctrl_value` is 0 and `irq` is 0.
- R2: A host write changes a bit only when all four of these hold in the same cycle: `cmd_valid`, `cmd_write`, an address that selects the register, and a 1 in that bit of `cmd_wmask`. A bit that is masked, or a command that is not valid, leaves the register unchanged.
- R3: In the status register at byte offset 0x08, writing 1 to a low-group bit clears it. Writing 0 to a low-group bit leaves it unchanged.
- R4: In the status register, writing 0 to a high-group bit clears it. Writing 1 to a high-group bit leaves it unchanged.
- R5: A 1 on bit i of `stat_set_hw` sets status bit i at the next clock edge. If a host clear hits the same bit in the same cycle, the hardware set wins and the bit stays 1.
- R6: In the control register at byte offset 0x04, writing 1 to a low-group bit sets it and writing 0 to a high-group bit sets it. Writing the opposite value has no effect.
- R7: A 1 on bit i of `ctrl_clr_hw` clears control bit i at the next edge. If a host set hits the same bit in the same cycle, the host set wins.
- R8: Bit i of the enable register at byte offset 0x00 gates status bit i. `irq` is a register loaded each cycle with the OR of (enable AND status). It therefore changes one edge after the field values change.
- R9: Any address other than 0x00, 0x04 or 0x08 is unmapped, and this includes addresses whose two low bits are not 0. A read of an unmapped address returns 0, and a write to one changes no register.
- R10: Bits of a register outside its two groups always read 0, even after 1s are written to them.
- R11: `ctrl_value` always equals the control register fields, ordered {high group, low group}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_wdata | input | DATA_W | Write data |
| cmd_wmask | input | DATA_W | Per-bit write mask |
| rd_data | output | DATA_W | Read data for `cmd_addr` |
| stat_set_hw | input | 2*NUM_SRC | Per-bit hardware set of status bits |
| ctrl_clr_hw | input | 2*NUM_SRC | Per-bit hardware clear of control bits |
| ctrl_value | output | 2*NUM_SRC | Current control fields |
| irq | output | 1 | Registered interrupt request |

## Verification
A wrong status or enable bit shows on `irq` exactly one edge after the bad value arises. It is also visible in the next read of the affected register. A wrong polarity or a wrong priority shows at once in the read data of the same register, and in `ctrl_value` on the cycle after the write. A decode error on an unmapped or misaligned address shows up when a mapped register is read again and has lost a bit.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int unsigned WORD_LSB = 2;

  typedef enum logic [1:0] {
    SEL_EN   = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } bank_sel_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output bank_sel_e         sel
);
  logic [ADDR_W-1:0] word_idx;

  always_comb begin
    word_idx = addr >> WORD_LSB;
    sel      = SEL_NONE;
    if (addr[WORD_LSB-1:0] == '0) begin
      if (word_idx == ADDR_W'(0)) sel = SEL_EN;
      else if (word_idx == ADDR_W'(1)) sel = SEL_CTRL;
      else if (word_idx == ADDR_W'(2)) sel = SEL_STAT;
    end
  end
endmodule

// File: rtl/irq_wclr_field.sv
module irq_wclr_field #(
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] INIT   = '0,
  parameter logic        CLR_POL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] wmask,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  logic [W-1:0] clr_hit;
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    clr_hit = {W{wr_en}} & wmask & ~(wdata ^ {W{CLR_POL}});
    q_d     = (q & ~clr_hit) | hw_set;
    q_en    = |(clr_hit | hw_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= INIT;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/irq_wset_field.sv
module irq_wset_field #(
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] INIT   = '0,
  parameter logic        SET_POL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] wmask,
  input  logic [W-1:0] hw_clr,
  output logic [W-1:0] q
);
  logic [W-1:0] set_hit;
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    set_hit = {W{wr_en}} & wmask & ~(wdata ^ {W{SET_POL}});
    q_d     = (q & ~hw_clr) | set_hit;
    q_en    = |(set_hit | hw_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= INIT;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/irq_rw_field.sv
module irq_rw_field #(
  parameter int unsigned W     = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] wmask,
  output logic [W-1:0] q
);
  logic [W-1:0] hit;
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    hit  = {W{wr_en}} & wmask;
    q_d  = (q & ~hit) | (wdata & hit);
    q_en = |hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= INIT;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int unsigned N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] enable,
  input  logic [N-1:0] status,
  output logic         irq
);
  logic irq_d;

  always_comb irq_d = |(enable & status);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_bank_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_SRC   = 2,
  parameter int unsigned HI_LSB    = 16,
  parameter logic [2*NUM_SRC-1:0] EN_INIT   = '0,
  parameter logic [2*NUM_SRC-1:0] CTRL_INIT = '0,
  parameter logic [2*NUM_SRC-1:0] STAT_INIT = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic                 cmd_write,
  input  logic [ADDR_W-1:0]    cmd_addr,
  input  logic [DATA_W-1:0]    cmd_wdata,
  input  logic [DATA_W-1:0]    cmd_wmask,
  output logic [DATA_W-1:0]    rd_data,
  input  logic [2*NUM_SRC-1:0] stat_set_hw,
  input  logic [2*NUM_SRC-1:0] ctrl_clr_hw,
  output logic [2*NUM_SRC-1:0] ctrl_value,
  output logic                 irq
);
  localparam int unsigned NV     = 2 * NUM_SRC;
  localparam int unsigned GROUPS = 2;

  logic          rst_n_sync;
  bank_sel_e     sel;
  logic          wr_cmd;
  logic [NV-1:0] en_q;
  logic [NV-1:0] ctrl_q;
  logic [NV-1:0] stat_q;

  irq_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  irq_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (cmd_addr),
    .sel  (sel)
  );

  assign wr_cmd = cmd_valid & cmd_write;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam int unsigned LANE = (g == 0) ? 0 : HI_LSB;
    localparam logic        POL  = (g == 0) ? 1'b1 : 1'b0;

    irq_rw_field #(
      .W    (NUM_SRC),
      .INIT (EN_INIT[g*NUM_SRC +: NUM_SRC])
    ) u_en (
      .clk   (clk),
      .rst_n (rst_n_sync),
      .wr_en (wr_cmd && sel == SEL_EN),
      .wdata (cmd_wdata[LANE +: NUM_SRC]),
      .wmask (cmd_wmask[LANE +: NUM_SRC]),
      .q     (en_q[g*NUM_SRC +: NUM_SRC])
    );

    irq_wset_field #(
      .W       (NUM_SRC),
      .INIT    (CTRL_INIT[g*NUM_SRC +: NUM_SRC]),
      .SET_POL (POL)
    ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n_sync),
      .wr_en  (wr_cmd && sel == SEL_CTRL),
      .wdata  (cmd_wdata[LANE +: NUM_SRC]),
      .wmask  (cmd_wmask[LANE +: NUM_SRC]),
      .hw_clr (ctrl_clr_hw[g*NUM_SRC +: NUM_SRC]),
      .q      (ctrl_q[g*NUM_SRC +: NUM_SRC])
    );

    irq_wclr_field #(
      .W       (NUM_SRC),
      .INIT    (STAT_INIT[g*NUM_SRC +: NUM_SRC]),
      .CLR_POL (POL)
    ) u_stat (
      .clk    (clk),
      .rst_n  (rst_n_sync),
      .wr_en  (wr_cmd && sel == SEL_STAT),
      .wdata  (cmd_wdata[LANE +: NUM_SRC]),
      .wmask  (cmd_wmask[LANE +: NUM_SRC]),
      .hw_set (stat_set_hw[g*NUM_SRC +: NUM_SRC]),
      .q      (stat_q[g*NUM_SRC +: NUM_SRC])
    );
  end

  if (NV > 0) begin : g_irq
    irq_combine #(.N(NV)) u_combine (
      .clk    (clk),
      .rst_n  (rst_n_sync),
      .enable (en_q),
      .status (stat_q),
      .irq    (irq)
    );
  end else begin : g_no_irq
    assign irq = 1'b0;
  end

  always_comb begin
    logic [NV-1:0] pick;
    case (sel)
      SEL_EN:   pick = en_q;
      SEL_CTRL: pick = ctrl_q;
      SEL_STAT: pick = stat_q;
      default:  pick = '0;
    endcase
    rd_data                   = '0;
    rd_data[0 +: NUM_SRC]      = pick[0 +: NUM_SRC];
    rd_data[HI_LSB +: NUM_SRC] = pick[NUM_SRC +: NUM_SRC];
  end

  assign ctrl_value = ctrl_q;
endmodule

// File: rtl/irq_status_bank_chk.sv
module irq_status_bank_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NV     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_write,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic [NV-1:0]     stat_set_hw,
  input logic [NV-1:0]     ctrl_clr_hw,
  input logic [NV-1:0]     ctrl_value,
  input logic [NV-1:0]     en_q,
  input logic [NV-1:0]     stat_q,
  input logic              irq
);
  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(en_q & stat_q)) |=> irq);

  // R8
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(en_q & stat_q)) |=> !irq);

  // R5
  hw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat_set_hw) |=> ((stat_q & $past(stat_set_hw)) == $past(stat_set_hw)));

  // R7
  hw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ctrl_clr_hw) && !(cmd_valid && cmd_write)) |=> ((ctrl_value & $past(ctrl_clr_hw)) == '0));

  // R2
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cmd_valid && cmd_write) && stat_set_hw == '0) |=> $stable(stat_q));

  // R2
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_write) |=> $stable(en_q));

  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_addr[1:0] != 2'b00) || (cmd_addr[ADDR_W-1:2] > 2)) |-> (rd_data == '0));
endmodule

bind irq_status_bank irq_status_bank_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .NV     (2 * NUM_SRC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .cmd_valid   (cmd_valid),
  .cmd_write   (cmd_write),
  .cmd_addr    (cmd_addr),
  .rd_data     (rd_data),
  .stat_set_hw (stat_set_hw),
  .ctrl_clr_hw (ctrl_clr_hw),
  .ctrl_value  (ctrl_value),
  .en_q        (en_q),
  .stat_q      (stat_q),
  .irq         (irq)
);

// File: tb/irq_status_bank_test.sv
module irq_status_bank_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_write;
  logic [7:0]  cmd_addr;
  logic [31:0] cmd_wdata, cmd_wmask;
  logic [31:0] rd_data;
  logic [3:0]  stat_set_hw, ctrl_clr_hw, ctrl_value;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;

  rd_item_t exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  irq_status_bank uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_write   (cmd_write),
    .cmd_addr    (cmd_addr),
    .cmd_wdata   (cmd_wdata),
    .cmd_wmask   (cmd_wmask),
    .rd_data     (rd_data),
    .stat_set_hw (stat_set_hw),
    .ctrl_clr_hw (ctrl_clr_hw),
    .ctrl_value  (ctrl_value),
    .irq         (irq)
  );

  // Monitor: compares read data at the falling edge of each read cycle
  always @(negedge clk) begin
    if (rst_n && cmd_valid && !cmd_write && exp_q.size() > 0) begin
      rd_item_t it;
      it = exp_q.pop_front();
      checks++;
      if (rd_data !== it.exp) begin
        errors++;
        $display("FAIL %s: addr=%h actual=%h expected=%h", it.tag, cmd_addr, rd_data, it.exp);
      end
    end
  end

  task automatic drive(input logic v, input logic w, input logic [7:0] a,
                       input logic [31:0] d, input logic [31:0] m,
                       input logic [3:0] sset, input logic [3:0] cclr);
    @(posedge clk); #1;
    cmd_valid = v; cmd_write = w; cmd_addr = a; cmd_wdata = d; cmd_wmask = m;
    stat_set_hw = sset; ctrl_clr_hw = cclr;
    @(posedge clk); #1;
    cmd_valid = 0; cmd_write = 0; cmd_addr = 0; cmd_wdata = 0; cmd_wmask = 0;
    stat_set_hw = 0; ctrl_clr_hw = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [31:0] m);
    drive(1, 1, a, d, m, 4'b0, 4'b0);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    rd_item_t it;
    it.exp = e;
    it.tag = tag;
    exp_q.push_back(it);
    drive(1, 0, a, 32'h0, 32'h0, 4'b0, 4'b0);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_write = 0; cmd_addr = 0; cmd_wdata = 0;
    cmd_wmask = 0; stat_set_hw = 0; ctrl_clr_hw = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk({31'b0, irq}, 0, "R1 irq");
    chk({28'b0, ctrl_value}, 0, "R1 ctrl_value");
    rd(8'h00, 32'h0, "R1 enable");
    rd(8'h04, 32'h0, "R1 control");
    rd(8'h08, 32'h0, "R1 status");

    // R5 hardware set, one bit in each group
    drive(0, 0, 8'h0, 0, 0, 4'b0101, 4'b0);
    rd(8'h08, 32'h0001_0001, "R5 hw set");
    chk({31'b0, irq}, 0, "R8 disabled source");

    // R8 enable both set sources; irq one edge later
    wr(8'h00, 32'h0001_0001, 32'hFFFF_FFFF);
    chk({31'b0, irq}, 0, "R8 not before next edge");
    @(posedge clk); #1;
    chk({31'b0, irq}, 1, "R8 asserted");
    rd(8'h00, 32'h0001_0001, "R8 enable readback");

    // R4 write 0 clears high group; R3 write 0 leaves low group
    wr(8'h08, 32'h0, 32'hFFFF_FFFF);
    rd(8'h08, 32'h0000_0001, "R3/R4 zero write");

    // R2 masked write and invalid command
    wr(8'h08, 32'h0000_0001, 32'h0);
    rd(8'h08, 32'h0000_0001, "R2 masked");
    drive(0, 1, 8'h08, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0, 4'b0);
    rd(8'h08, 32'h0000_0001, "R2 not valid");

    // R3 write 1 clears low group; R4 write 1 no effect
    wr(8'h08, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk({31'b0, irq}, 1, "R8 still high one edge");
    @(posedge clk); #1;
    chk({31'b0, irq}, 0, "R8 dropped");
    rd(8'h08, 32'h0, "R3 one write");

    // R5 hw set wins over host clear
    drive(0, 0, 8'h0, 0, 0, 4'b1100, 4'b0);
    rd(8'h08, 32'h0003_0000, "R5 hw set high");
    drive(1, 1, 8'h08, 32'h0, 32'hFFFF_FFFF, 4'b0100, 4'b0);
    rd(8'h08, 32'h0001_0000, "R5 priority");

    // R6 host set in both polarities
    wr(8'h04, 32'h0000_0002, 32'hFFFF_FFFF);
    chk({28'b0, ctrl_value}, 32'hE, "R11 after set");
    rd(8'h04, 32'h0003_0002, "R6 set");

    // R7 hw clear
    drive(0, 0, 8'h0, 0, 0, 4'b0, 4'b0110);
    rd(8'h04, 32'h0002_0000, "R7 hw clear");
    chk({28'b0, ctrl_value}, 32'h8, "R11 after clear");

    // R7 host set wins
    drive(1, 1, 8'h04, 32'h1, 32'h1, 4'b0, 4'b0001);
    rd(8'h04, 32'h0002_0001, "R7 priority");
    chk({28'b0, ctrl_value}, 32'h9, "R11 after priority");

    // R6 writing 1 to high group has no effect
    wr(8'h04, 32'hFFFF_FFFF, 32'h0001_0000);
    rd(8'h04, 32'h0002_0001, "R6 opposite value");

    // R9 unmapped and misaligned
    wr(8'h0C, 32'h0, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    wr(8'h09, 32'h0, 32'hFFFF_FFFF);
    wr(8'h01, 32'h0, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h0, "R9 read 0x0C");
    rd(8'hFC, 32'h0, "R9 read 0xFC");
    rd(8'h09, 32'h0, "R9 read misaligned");
    rd(8'h00, 32'h0001_0001, "R9 enable intact");
    rd(8'h04, 32'h0002_0001, "R9 control intact");
    rd(8'h08, 32'h0001_0000, "R9 status intact");

    // R8 high-group source drives irq; disabling drops it
    chk({31'b0, irq}, 1, "R8 high group");
    wr(8'h00, 32'h0, 32'h0001_0000);
    chk({31'b0, irq}, 1, "R8 disable delay");
    @(posedge clk); #1;
    chk({31'b0, irq}, 0, "R8 disabled");

    // R10 unused bits read zero
    wr(8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0003_0003, "R10 unused bits");

    repeat (2) @(posedge clk);
    chk(exp_q.size(), 0, "scoreboard drained");
    finish_run();
  end
endmodule